// File: doc/BRIEF.md
# Multi-Rate TDM Stream Timing Generator

This block produces the bit, channel and frame timing for a bank of serial TDM streams that all share one 125 µs frame. It runs from a 16.384 MHz timing clock, so one frame is 2048 clock cycles. Each stream has two 4-bit rate settings, one for its input side and one for its output side, and the two are set independently. Each setting picks 2.048, 4.096, 8.192 or 16.384 Mbps, which gives that side of the stream 32, 64, 128 or 256 eight-bit channels per frame. Every stream side gets its own bit strobe and current channel index. One common frame pulse marks the start of every frame.

A capacity checker adds up the channel counts of all enabled stream sides in each direction. It raises a registered error flag when either sum is over the switching capacity of 2048 channels. Only whole streams count toward the sum. Two group mode bits are also provided, one for the lower half of the streams and one for the upper half. Each bit ties the serial inputs of its half low and marks the outputs of that half as bidirectional.

Top module: `tdm_stream_timing`

## Requirements
- R1: `frame_o` is high for exactly one cycle out of every 2048 cycles.
- R2: A stream side with rate code 0, 1, 2 or 3 strobes its bit strobe every 8, 4, 2 or 1 cycles. The strobe is high in the cycle where `frame_o` is high.
- R3: Let t be the number of cycles since the last `frame_o` cycle. A side with rate code c in 0..3 shows channel index t >> (6 - c), an 8-bit field at bits [8*n+7:8*n] of the channel port for stream n. The index is 0 whenever `frame_o` is high.
- R4: Rate codes 4 to 15 disable a stream side. A disabled side holds its strobe low and its channel index at 0, and it adds nothing to the capacity sum.
- R5: A write with `cfg_dir_i`=0 sets the input rate of stream `cfg_idx_i`, and a write with `cfg_dir_i`=1 sets its output rate. The input side and output side of a stream run at their own rates.
- R6: `cap_err_o` is high when the channel sum (32 << code per enabled side) of the input sides or of the output sides is over 2048. It follows the stored rates with one cycle of delay after the write takes effect.
- R7: A sum of exactly 2048 does not set `cap_err_o`. Eight streams at code 3, or all 32 at code 1, give exactly 2048. All 32 at code 0 give 1024.
- R8: While bit 6 of the stored mode byte is set, `stream_in_o[15:0]` is 0 and `bidir_o[15:0]` is all ones. Bit 7 does the same for streams 31:16. The two bits act independently of each other.
- R9: After reset every stream side is disabled, both mode bits are clear, and `cap_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 16.384 MHz timing clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Rate write strobe |
| cfg_dir_i | input | 1 | 0 selects the input rate, 1 selects the output rate |
| cfg_idx_i | input | 5 | Stream number for the write |
| cfg_rate_i | input | 4 | Rate code to store |
| mode_we_i | input | 1 | Mode byte write strobe |
| mode_i | input | 8 | Mode byte; bit 6 controls the lower group, bit 7 the upper group |
| stream_in_i | input | 32 | Raw serial inputs |
| stream_in_o | output | 32 | Serial inputs after group tie-low |
| bidir_o | output | 32 | Per-stream bidirectional output marker |
| in_bit_stb_o | output | 32 | Input-side bit strobes |
| in_chan_o | output | 256 | Input-side channel indices, 8 bits per stream |
| out_bit_stb_o | output | 32 | Output-side bit strobes |
| out_chan_o | output | 256 | Output-side channel indices, 8 bits per stream |
| frame_o | output | 1 | Common frame pulse |
| cap_err_o | output | 1 | Capacity exceeded |

## Verification
The bench targets the capacity boundary at exactly 2048 channels, one step above it, and the mix of disabled and enabled streams. A comparison written as greater-or-equal would flag the legal full configurations. A design that gave disabled codes any weight would flag the mixed case wrongly. Over one whole frame, the bench checks every strobe and channel index at all four rates, plus a disabled code and an input side and output side of the same stream set to different rates. A wrong shift or a channel counter that does not wrap would show up as a bad index at a channel boundary or just after the frame pulse. The two mode bits are set one at a time and then together, so a swapped or shared group control shows up at the tied inputs.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;
  localparam int unsigned RATE_W      = 4;
  localparam int unsigned RATE_LEVELS = 4;
  localparam int unsigned MODE_W      = 8;
  localparam int unsigned GRP_LO_BIT  = 6;
  localparam int unsigned GRP_HI_BIT  = 7;

  typedef logic [RATE_W-1:0] rate_t;

  localparam rate_t RATE_OFF = 4'hF;

  function automatic logic rate_on(rate_t code);
    return code < rate_t'(RATE_LEVELS);
  endfunction
endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int unsigned FRAME_CYCLES = 2048,
  localparam int unsigned FRAME_W     = $clog2(FRAME_CYCLES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [FRAME_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_o <= '0;
    else if (cnt_o == FRAME_W'(FRAME_CYCLES - 1))  cnt_o <= '0;
    else                                           cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tdm_rate_regs.sv
module tdm_rate_regs
  import tdm_timing_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         dir_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  rate_t                        rate_i,
  input  logic                         mode_we_i,
  input  logic [MODE_W-1:0]            mode_i,
  output rate_t [NUM_STREAMS-1:0]      in_rate_o,
  output rate_t [NUM_STREAMS-1:0]      out_rate_o,
  output logic  [1:0]                  grp_o
);
  logic unused_mode;
  assign unused_mode = ^{mode_i[GRP_LO_BIT-1:0]};

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_rate_o[s]  <= RATE_OFF;
        out_rate_o[s] <= RATE_OFF;
      end else if (we_i && idx_i == IDX_W'(s)) begin
        if (dir_i) out_rate_o[s] <= rate_i;
        else       in_rate_o[s]  <= rate_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        grp_o <= '0;
    else if (mode_we_i) grp_o <= {mode_i[GRP_HI_BIT], mode_i[GRP_LO_BIT]};
  end
endmodule

// File: rtl/tdm_stream_gen.sv
module tdm_stream_gen
  import tdm_timing_pkg::*;
#(
  parameter int unsigned FRAME_W = 11,
  parameter int unsigned CH_W    = 8,
  parameter int unsigned BIT_SH  = 3,
  parameter int unsigned BASE_SH = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] frame_cnt_i,
  input  rate_t              rate_i,
  output logic               stb_o,
  output logic [CH_W-1:0]    chan_o
);
  logic [3:0]         bit_sh, ch_sh;
  logic [FRAME_W-1:0] bit_mask, chan_full;
  logic               en, stb_d;
  logic [CH_W-1:0]    chan_d;

  always_comb begin
    en        = rate_on(rate_i);
    bit_sh    = 4'(BIT_SH) - rate_i;
    ch_sh     = 4'(FRAME_W - BASE_SH) - rate_i;
    bit_mask  = FRAME_W'((32'd1 << bit_sh) - 32'd1);
    chan_full = frame_cnt_i >> ch_sh;
    stb_d     = en && ((frame_cnt_i & bit_mask) == '0);
    chan_d    = en ? chan_full[CH_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= 1'b0;
      chan_o <= '0;
    end else begin
      stb_o  <= stb_d;
      chan_o <= chan_d;
    end
  end
endmodule

// File: rtl/tdm_cap_check.sv
module tdm_cap_check
  import tdm_timing_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 32,
  parameter int unsigned BASE_CH     = 32,
  parameter int unsigned CAPACITY    = 2048,
  localparam int unsigned SUM_W      = $clog2(NUM_STREAMS * BASE_CH * 8) + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  rate_t [NUM_STREAMS-1:0] in_rate_i,
  input  rate_t [NUM_STREAMS-1:0] out_rate_i,
  output logic                    err_o
);
  logic [SUM_W-1:0] sum_in, sum_out;

  always_comb begin
    sum_in  = '0;
    sum_out = '0;
    for (int s = 0; s < NUM_STREAMS; s++) begin
      if (rate_on(in_rate_i[s]))  sum_in  = sum_in  + (SUM_W'(BASE_CH) << in_rate_i[s]);
      if (rate_on(out_rate_i[s])) sum_out = sum_out + (SUM_W'(BASE_CH) << out_rate_i[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= (sum_in > SUM_W'(CAPACITY)) || (sum_out > SUM_W'(CAPACITY));
  end
endmodule

// File: rtl/tdm_stream_timing.sv
module tdm_stream_timing
  import tdm_timing_pkg::*;
#(
  parameter int unsigned NUM_STREAMS  = 32,
  parameter int unsigned FRAME_CYCLES = 2048,
  parameter int unsigned BASE_CH      = 32,
  parameter int unsigned BITS_PER_CH  = 8,
  parameter int unsigned CAPACITY     = 2048,
  parameter int unsigned CH_W         = 8,
  localparam int unsigned IDX_W       = $clog2(NUM_STREAMS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic                        cfg_dir_i,
  input  logic [IDX_W-1:0]            cfg_idx_i,
  input  logic [3:0]                  cfg_rate_i,
  input  logic                        mode_we_i,
  input  logic [7:0]                  mode_i,
  input  logic [NUM_STREAMS-1:0]      stream_in_i,
  output logic [NUM_STREAMS-1:0]      stream_in_o,
  output logic [NUM_STREAMS-1:0]      bidir_o,
  output logic [NUM_STREAMS-1:0]      in_bit_stb_o,
  output logic [NUM_STREAMS*CH_W-1:0] in_chan_o,
  output logic [NUM_STREAMS-1:0]      out_bit_stb_o,
  output logic [NUM_STREAMS*CH_W-1:0] out_chan_o,
  output logic                        frame_o,
  output logic                        cap_err_o
);
  localparam int unsigned FRAME_W = $clog2(FRAME_CYCLES);
  localparam int unsigned BIT_SH  = $clog2(BITS_PER_CH);
  localparam int unsigned BASE_SH = $clog2(BASE_CH);
  localparam int unsigned GROUPS  = 2;
  localparam int unsigned GRP_SZ  = NUM_STREAMS / GROUPS;

  logic [FRAME_W-1:0]        frame_cnt;
  rate_t [NUM_STREAMS-1:0]   in_rate, out_rate;
  logic  [GROUPS-1:0]        grp;

  tdm_frame_ctr #(.FRAME_CYCLES(FRAME_CYCLES)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(frame_cnt)
  );

  tdm_rate_regs #(.NUM_STREAMS(NUM_STREAMS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .dir_i(cfg_dir_i), .idx_i(cfg_idx_i), .rate_i(cfg_rate_i),
    .mode_we_i(mode_we_i), .mode_i(mode_i),
    .in_rate_o(in_rate), .out_rate_o(out_rate), .grp_o(grp)
  );

  tdm_cap_check #(
    .NUM_STREAMS(NUM_STREAMS), .BASE_CH(BASE_CH), .CAPACITY(CAPACITY)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_rate_i(in_rate), .out_rate_i(out_rate), .err_o(cap_err_o)
  );

  // frame pulse registered to line up with the stream pipelines
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_o <= 1'b0;
    else         frame_o <= (frame_cnt == '0);
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    tdm_stream_gen #(
      .FRAME_W(FRAME_W), .CH_W(CH_W), .BIT_SH(BIT_SH), .BASE_SH(BASE_SH)
    ) u_in (
      .clk_i(clk_i), .rst_ni(rst_ni), .frame_cnt_i(frame_cnt), .rate_i(in_rate[s]),
      .stb_o(in_bit_stb_o[s]), .chan_o(in_chan_o[s*CH_W +: CH_W])
    );
    tdm_stream_gen #(
      .FRAME_W(FRAME_W), .CH_W(CH_W), .BIT_SH(BIT_SH), .BASE_SH(BASE_SH)
    ) u_out (
      .clk_i(clk_i), .rst_ni(rst_ni), .frame_cnt_i(frame_cnt), .rate_i(out_rate[s]),
      .stb_o(out_bit_stb_o[s]), .chan_o(out_chan_o[s*CH_W +: CH_W])
    );
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign bidir_o[g*GRP_SZ +: GRP_SZ]     = {GRP_SZ{grp[g]}};
    assign stream_in_o[g*GRP_SZ +: GRP_SZ] = stream_in_i[g*GRP_SZ +: GRP_SZ] & ~{GRP_SZ{grp[g]}};
  end
endmodule

// File: rtl/tdm_timing_chk.sv
module tdm_timing_chk #(
  parameter int unsigned NUM_STREAMS  = 32,
  parameter int unsigned FRAME_CYCLES = 2048,
  parameter int unsigned CH_W         = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_o,
  input logic [NUM_STREAMS-1:0]      stream_in_o,
  input logic [NUM_STREAMS-1:0]      bidir_o,
  input logic [NUM_STREAMS*CH_W-1:0] in_chan_o,
  input logic [NUM_STREAMS*CH_W-1:0] out_chan_o
);
  localparam int unsigned GAP_W = $clog2(FRAME_CYCLES) + 1;
  localparam int unsigned HALF  = NUM_STREAMS / 2;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (frame_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_FRAME_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_o && seen_q) |-> (gap_q == GAP_W'(FRAME_CYCLES - 1))); // R1
  AST_FRAME_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o); // R1
  AST_CHAN_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> (in_chan_o == '0 && out_chan_o == '0)); // R3
  AST_BIDIR_TIE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stream_in_o & bidir_o) == '0); // R8
  AST_BIDIR_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(bidir_o[HALF-1:0]) == 0 || $countones(bidir_o[HALF-1:0]) == HALF) &&
    ($countones(bidir_o[NUM_STREAMS-1:HALF]) == 0 ||
     $countones(bidir_o[NUM_STREAMS-1:HALF]) == HALF)); // R8
endmodule

bind tdm_stream_timing tdm_timing_chk #(
  .NUM_STREAMS(NUM_STREAMS), .FRAME_CYCLES(FRAME_CYCLES), .CH_W(CH_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_o(frame_o), .stream_in_o(stream_in_o),
  .bidir_o(bidir_o), .in_chan_o(in_chan_o), .out_chan_o(out_chan_o)
);

// File: tb/test_tdm_stream_timing.sv
module test_tdm_stream_timing;
  localparam int N = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [4:0]    cfg_idx = '0;
  logic [3:0]    cfg_rate = '0;
  logic          mode_we = 1'b0;
  logic [7:0]    mode = '0;
  logic [N-1:0]  sin = '0;
  logic [N-1:0]  sin_o, bidir, in_stb, out_stb;
  logic [N*CW-1:0] in_chan, out_chan;
  logic          frame, cap_err;

  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  tdm_stream_timing i_tdm_stream_timing (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_dir_i(cfg_dir),
    .cfg_idx_i(cfg_idx), .cfg_rate_i(cfg_rate), .mode_we_i(mode_we), .mode_i(mode),
    .stream_in_i(sin), .stream_in_o(sin_o), .bidir_o(bidir),
    .in_bit_stb_o(in_stb), .in_chan_o(in_chan), .out_bit_stb_o(out_stb),
    .out_chan_o(out_chan), .frame_o(frame), .cap_err_o(cap_err)
  );

  // {count of streams, code for them, code for the rest, expected error}
  localparam logic [14:0] VEC [8] = '{
    {6'd32, 4'd0, 4'hF, 1'b0},   // 1024
    {6'd32, 4'd1, 4'hF, 1'b0},   // exactly 2048
    {6'd8,  4'd3, 4'hF, 1'b0},   // exactly 2048
    {6'd9,  4'd3, 4'hF, 1'b1},   // 2304
    {6'd16, 4'd2, 4'hF, 1'b0},   // 2048
    {6'd16, 4'd2, 4'd0, 1'b1},   // 2560
    {6'd0,  4'd3, 4'h9, 1'b0},   // all disabled
    {6'd32, 4'd2, 4'hF, 1'b1}    // 4096
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_rate(input logic dir, input int idx, input logic [3:0] code);
    cfg_we = 1'b1; cfg_dir = dir; cfg_idx = 5'(idx); cfg_rate = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] m);
    mode_we = 1'b1; mode = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic fill(input logic dir, input int n, input logic [3:0] fast, input logic [3:0] rest);
    for (int i = 0; i < N; i++) wr_rate(dir, i, (i < n) ? fast : rest);
  endtask

  function automatic logic exp_stb(input logic [3:0] c, input int t);
    return (c < 4) && ((t % (8 >> c)) == 0);
  endfunction

  function automatic int exp_chan(input logic [3:0] c, input int t);
    return (c < 4) ? (t / (64 >> c)) : 0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [3:0] in_code [5];
    logic [3:0] out_code [2];
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sin = '1;
    @(negedge clk);
    // R9 reset state
    chk("R9 cap_err", 32'(cap_err), 0);
    chk("R9 bidir", bidir, 0);
    chk("R9 inputs pass", sin_o, 32'hFFFF_FFFF);
    chk("R9 in strobes off", in_stb, 0);
    chk("R9 out strobes off", out_stb, 0);

    // capacity table on input side: R6 R7 R4
    foreach (VEC[v]) begin
      fill(1'b0, int'(VEC[v][14:9]), VEC[v][8:5], VEC[v][4:1]);
      @(negedge clk); @(negedge clk);
      chk($sformatf("R6/R7 capacity vector %0d", v), 32'(cap_err), 32'(VEC[v][0]));
    end

    // output side checked on its own: R5 R6
    fill(1'b0, 0, 4'd0, 4'hF);
    fill(1'b1, 9, 4'd3, 4'hF);
    @(negedge clk); @(negedge clk);
    chk("R5 output side over capacity", 32'(cap_err), 1);
    wr_rate(1'b1, 8, 4'hC);
    @(negedge clk); @(negedge clk);
    chk("R4 disabled output stream drops from sum", 32'(cap_err), 0);
    fill(1'b1, 0, 4'd0, 4'hF);

    // timing over one frame: R1 R2 R3 R4 R5
    in_code  = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5};
    out_code = '{4'd3, 4'd0};
    for (int i = 0; i < 5; i++) wr_rate(1'b0, i, in_code[i]);
    for (int i = 0; i < 2; i++) wr_rate(1'b1, i, out_code[i]);
    @(negedge clk);
    while (!frame) @(negedge clk);
    t = 0;
    repeat (2049) begin
      int tf;
      tf = t % 2048;
      chk($sformatf("R1 frame t=%0d", t), 32'(frame), 32'(tf == 0));
      for (int i = 0; i < 5; i++) begin
        chk($sformatf("R2 in stb s%0d t=%0d", i, t), 32'(in_stb[i]), 32'(exp_stb(in_code[i], tf)));
        chk($sformatf("R3 in chan s%0d t=%0d", i, t), 32'(in_chan[i*CW +: CW]), 32'(exp_chan(in_code[i], tf)));
      end
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("R5 out stb s%0d t=%0d", i, t), 32'(out_stb[i]), 32'(exp_stb(out_code[i], tf)));
        chk($sformatf("R5 out chan s%0d t=%0d", i, t), 32'(out_chan[i*CW +: CW]), 32'(exp_chan(out_code[i], tf)));
      end
      chk("R4 unconfigured streams idle", in_stb & 32'hFFFF_FFE0, 0);
      @(negedge clk);
      t++;
    end

    // group mode bits: R8
    wr_mode(8'h40);
    chk("R8 low group inputs", sin_o, 32'hFFFF_0000);
    chk("R8 low group bidir", bidir, 32'h0000_FFFF);
    wr_mode(8'h80);
    chk("R8 high group inputs", sin_o, 32'h0000_FFFF);
    chk("R8 high group bidir", bidir, 32'hFFFF_0000);
    wr_mode(8'hC0);
    chk("R8 both groups inputs", sin_o, 32'h0000_0000);
    chk("R8 both groups bidir", bidir, 32'hFFFF_FFFF);
    wr_mode(8'h3F);
    chk("R8 other mode bits no effect", sin_o, 32'hFFFF_FFFF);
    chk("R8 other mode bits bidir", bidir, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule